// File: doc/BRIEF.md
# Two-Wire Slave Front End for a Paged Byte Store

This block is a slave on a two-wire serial bus (I2C) that fronts 512 bytes of storage held in an on-chip register array. Both bus lines are brought onto a fast system clock through a synchroniser. The block detects the bus start and stop conditions, then receives a device address, a word address and data bytes. It acknowledges by pulling the data line low through an open-drain enable. The storage is organised as two halves of 256 bytes. The lowest address bit of the device address picks the half. Each half is cut into 32 pages of 8 bytes.

A write burst stays inside the page that its word address falls in. After the eighth byte of a page, the next byte lands back on the first byte of that same page. Reads work differently. Either the current pointer is read, or the master writes a word address and then issues a repeated start in the read direction. During a read the pointer walks freely across page boundaries and folds back to 00h at the end of the selected half. The master ends a read by withholding its acknowledge.

Top module: `i2c_paged_store`

## Requirements
- R1: A fall of SDA while SCL is high is a START, and a rise of SDA while SCL is high is a STOP. A STOP returns the slave to idle with its SDA drive released.
- R2: The device address byte is sent MSB first as {6'b110100, half, dir}, where dir=1 means read. The slave pulls SDA low in the ninth clock only when the upper six bits match. On a mismatch it drives nothing until the next START.
- R3: After a write-direction device address, the next byte is taken as the word address and is acknowledged.
- R4: Each data byte of a write is acknowledged and stored. Page n covers word addresses 8n to 8n+7. The next byte goes to the following location in the same page, and after offset 7 it wraps to offset 0 of that page.
- R5: The half bit of the device address selects the storage half, so the stored location is half*256 + word address. The two halves hold independent data.
- R6: A read sends bytes MSB first, starting at the current pointer. The pointer increments after each byte, crosses page boundaries, and wraps from FFh to 00h within the same half. Writing a word address followed by a repeated START gives a random read.
- R7: When the master does not acknowledge a read byte, the slave stops driving SDA until the next START or STOP.
- R8: A START that arrives in the middle of a byte discards the partial byte, and the following byte is received as a new device address.
- R9: The slave only asserts its SDA drive while the synchronised SCL is low. It works at any SCL period of at least 16 system clocks, which covers both 100 kHz and 400 kHz operation.
- R10: After reset the SDA drive is released and the slave is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sensed level of the bus clock line |
| sda_i | input | 1 | Sensed level of the bus data line |
| sda_oe | output | 1 | Pulls SDA low when high (open-drain enable) |

## Verification
Two functions can fall in the same cycle. The first is the commit of a data byte together with the step of the in-page pointer. The second is a repeated START arriving while a byte is half shifted, which must win over any bit shift pending in that cycle. The bench starts one write burst near the end of a page so that it wraps onto bytes it wrote itself. It reads the whole page back through a read that crosses into the next page. It also cuts a device byte short with a repeated START and checks that the restarted write lands intact. A scoreboard computes the expected bytes from a bench model of the page and half rules and compares them against what comes back on SDA.

// File: rtl/i2c_store_pkg.sv
package i2c_store_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_WADR, ST_WADR_ACK,
    ST_WDAT, ST_WDAT_ACK, ST_RDAT, ST_RACK, ST_SKIP
  } slv_state_t;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_prev;
  assign scl_fall  = ~scl_s & scl_prev;
  assign start_evt = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_evt  = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/paged_byte_ram.sv
module paged_byte_ram #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_store_pkg::*;
#(
  parameter logic [5:0] DEV_ID = 6'b110100,
  parameter int         WA_W   = 8,
  parameter int         PG_W   = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            scl_s,
  input  logic            sda_s,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            start_evt,
  input  logic            stop_evt,
  input  logic [7:0]      rd_data,
  output logic            wr_en,
  output logic [WA_W:0]   wr_addr,
  output logic [7:0]      wr_data,
  output logic [WA_W:0]   rd_addr,
  output logic            sda_oe
);
  slv_state_t       state;
  logic [3:0]       cnt;
  logic [7:0]       shreg, tx;
  logic [WA_W-1:0]  ptr;
  logic             half, dir, mack;

  assign rd_addr = {half, ptr};

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; cnt <= '0; shreg <= '0; tx <= '0; ptr <= '0;
      half <= 1'b0; dir <= 1'b0; mack <= 1'b0; sda_oe <= 1'b0;
      wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (stop_evt) begin
        state <= ST_IDLE; sda_oe <= 1'b0; cnt <= '0;
      end else if (start_evt) begin
        state <= ST_DEV; sda_oe <= 1'b0; cnt <= '0;
      end else begin
        case (state)
          ST_DEV, ST_WADR, ST_WDAT: begin
            if (scl_rise && cnt != 4'd8) begin
              shreg <= {shreg[6:0], sda_s};
              cnt   <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              if (state == ST_DEV) begin
                if (shreg[7:2] == DEV_ID) begin
                  half <= shreg[1]; dir <= shreg[0];
                  sda_oe <= 1'b1; state <= ST_DEV_ACK;
                end else begin
                  state <= ST_SKIP;
                end
              end else if (state == ST_WADR) begin
                ptr <= shreg[WA_W-1:0]; sda_oe <= 1'b1; state <= ST_WADR_ACK;
              end else begin
                wr_en   <= 1'b1;
                wr_data <= shreg;
                wr_addr <= {half, ptr};
                ptr     <= {ptr[WA_W-1:PG_W], ptr[PG_W-1:0] + 1'b1};
                sda_oe  <= 1'b1;
                state   <= ST_WDAT_ACK;
              end
            end
          end
          ST_DEV_ACK: if (scl_fall) begin
            cnt <= '0;
            if (dir) begin
              tx <= rd_data; sda_oe <= ~rd_data[7]; state <= ST_RDAT;
            end else begin
              sda_oe <= 1'b0; state <= ST_WADR;
            end
          end
          ST_WADR_ACK, ST_WDAT_ACK: if (scl_fall) begin
            sda_oe <= 1'b0; state <= ST_WDAT;
          end
          ST_RDAT: begin
            if (scl_rise && cnt != 4'd8) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0; ptr <= ptr + 1'b1; cnt <= '0; state <= ST_RACK;
              end else begin
                sda_oe <= ~tx[3'd7 - cnt[2:0]];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) mack <= ~sda_s;
            else if (scl_fall) begin
              if (mack) begin
                tx <= rd_data; sda_oe <= ~rd_data[7]; state <= ST_RDAT;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R9
  sda_low_scl_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_s);

  // R4
  page_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (ptr[WA_W-1:PG_W] == wr_addr[WA_W-1:PG_W]) &&
              (ptr[PG_W-1:0] == wr_addr[PG_W-1:0] + 1'b1));

  // R1
  stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> (state == ST_IDLE) && !sda_oe);

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    (start_evt && !stop_evt) |=> (state == ST_DEV) && (cnt == 4'd0));

  // R2
  skip_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SKIP) |-> !sda_oe);
endmodule

// File: rtl/i2c_paged_store.sv
module i2c_paged_store #(
  parameter logic [5:0] DEV_ID      = 6'b110100,
  parameter int         WORD_ADDR_W = 8,
  parameter int         PAGE_W      = 3,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int MEM_AW = WORD_ADDR_W + 1;

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic              wr_en;
  logic [MEM_AW-1:0] wr_addr, rd_addr;
  logic [7:0]        wr_data, rd_data;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2c_slave_fsm #(.DEV_ID(DEV_ID), .WA_W(WORD_ADDR_W), .PG_W(PAGE_W)) u_fsm (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .sda_oe(sda_oe)
  );

  paged_byte_ram #(.AW(MEM_AW), .DW(8)) u_ram (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(rd_data)
  );
endmodule

// File: tb/i2c_paged_store_tb.sv
module i2c_paged_store_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;
  assign sda_line = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  i2c_paged_store u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int q_len = 10;
  bit done = 1'b0;
  logic [7:0] model [512];
  logic [7:0] exp_q [$];
  logic [7:0] got_q [$];
  string      tag_q [$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      wait (got_q.size() > 0);
      begin
        logic [7:0] g, e;
        string t;
        g = got_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(g == e, t, g, e);
      end
    end
  end

  task automatic hq(); repeat (q_len) @(negedge clk); endtask
  task automatic send_bit(input bit b);
    sda_m = b; hq(); scl_m = 1'b1; hq(); hq(); scl_m = 1'b0; hq();
  endtask
  task automatic recv_bit(output bit b);
    sda_m = 1'b1; hq(); scl_m = 1'b1; hq(); b = sda_line; hq(); scl_m = 1'b0; hq();
  endtask
  task automatic bus_start();
    sda_m = 1'b1; hq(); scl_m = 1'b1; hq(); sda_m = 1'b0; hq(); scl_m = 1'b0; hq();
  endtask
  task automatic bus_stop();
    sda_m = 1'b0; hq(); scl_m = 1'b1; hq(); sda_m = 1'b1; hq();
  endtask
  task automatic send_byte(input logic [7:0] v, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(b);
    ack = !b;
  endtask
  task automatic recv_byte(output logic [7:0] v, input bit give_ack);
    bit b;
    for (int i = 7; i >= 0; i--) begin recv_bit(b); v[i] = b; end
    send_bit(!give_ack);
  endtask

  function automatic logic [7:0] dev_byte(input bit half, input bit rd);
    return {6'b110100, half, rd};
  endfunction

  task automatic wr_txn(input bit half, input logic [7:0] wa, input int n, input logic [7:0] seed);
    bit ack;
    logic [7:0] v;
    bus_start();
    send_byte(dev_byte(half, 1'b0), ack); chk(ack, "R2 dev ack", ack, 1);
    send_byte(wa, ack);                   chk(ack, "R3 word addr ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      v = seed + 8'(i * 29);
      send_byte(v, ack); chk(ack, "R4 data ack", ack, 1);
      model[{half, wa[7:3], 3'(wa[2:0] + 3'(i))}] = v;
    end
    bus_stop();
  endtask

  task automatic rd_txn(input bit half, input logic [7:0] wa, input int n, input string t);
    bit ack;
    logic [7:0] v;
    bus_start();
    send_byte(dev_byte(half, 1'b0), ack); chk(ack, "R2 dev ack", ack, 1);
    send_byte(wa, ack);                   chk(ack, "R3 word addr ack", ack, 1);
    bus_start();
    send_byte(dev_byte(half, 1'b1), ack); chk(ack, "R6 read dev ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(model[{half, 8'(wa + 8'(i))}]);
      tag_q.push_back(t);
      recv_byte(v, i != n - 1);
      got_q.push_back(v);
    end
    bus_stop();
  endtask

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] v;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sda_oe == 1'b0, "R10 reset release", sda_oe, 0);
    repeat (20) @(negedge clk);

    // R3 R4 R6 basic write and read back
    wr_txn(1'b0, 8'h10, 4, 8'h31);
    rd_txn(1'b0, 8'h10, 4, "R6 basic readback");

    // R4 page wrap: 1E,1F,18,19,1A
    wr_txn(1'b0, 8'h18, 8, 8'h00);
    wr_txn(1'b0, 8'h1E, 5, 8'hA5);
    rd_txn(1'b0, 8'h18, 8, "R4 wrapped page");
    wr_txn(1'b0, 8'h20, 4, 8'h77);
    rd_txn(1'b0, 8'h1C, 8, "R6 cross page read");

    // R5 halves independent
    wr_txn(1'b1, 8'h10, 3, 8'hC3);
    rd_txn(1'b0, 8'h10, 3, "R5 half0");
    rd_txn(1'b1, 8'h10, 3, "R5 half1");

    // R6 read wrap FF->00 in half 1
    wr_txn(1'b1, 8'hFE, 2, 8'h5A);
    wr_txn(1'b1, 8'h00, 2, 8'h19);
    rd_txn(1'b1, 8'hFE, 4, "R6 block wrap");

    // R2 mismatch: no ack, no drive
    bus_start();
    send_byte(8'hA0, ack);
    chk(!ack, "R2 mismatch nack", ack, 0);
    recv_byte(v, 1'b0);
    chk(v == 8'hFF, "R2 mismatch silent", v, 8'hFF);
    bus_stop();
    @(negedge clk);
    chk(sda_oe == 1'b0, "R1 stop idle", sda_oe, 0);

    // R7 master nack ends read
    bus_start();
    send_byte(dev_byte(1'b0, 1'b0), ack); chk(ack, "R7 dev ack", ack, 1);
    send_byte(8'h10, ack);                chk(ack, "R7 addr ack", ack, 1);
    bus_start();
    send_byte(dev_byte(1'b0, 1'b1), ack); chk(ack, "R7 rd ack", ack, 1);
    recv_byte(v, 1'b0);
    chk(v == model[9'h010], "R7 first byte", v, model[9'h010]);
    recv_byte(v, 1'b0);
    chk(v == 8'hFF, "R7 released after nack", v, 8'hFF);
    bus_stop();

    // R8 repeated start mid byte
    bus_start();
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    bus_start();
    send_byte(dev_byte(1'b0, 1'b0), ack); chk(ack, "R8 restart dev ack", ack, 1);
    send_byte(8'h40, ack);                chk(ack, "R8 addr ack", ack, 1);
    send_byte(8'h9C, ack);                chk(ack, "R8 data ack", ack, 1);
    model[9'h040] = 8'h9C;
    bus_stop();
    rd_txn(1'b0, 8'h40, 1, "R8 restart write");

    // R9 slow bus (100 kHz at 100 MHz)
    q_len = 250;
    wr_txn(1'b1, 8'h80, 1, 8'h6E);
    rd_txn(1'b1, 8'h80, 1, "R9 slow rate");
    q_len = 10;

    wait (got_q.size() == 0);
    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule